// File: doc/BRIEF.md
# Gate-Kill Output Stage for a Three-Phase Inverter

This block sits between a three-phase PWM generator and the six gate-drive pins of an inverter bridge. Each of the three phases has a high-side and a low-side output. Every pin has its own polarity setting, so that the stage can feed drivers with either sense of input. The stage registers the PWM pattern once and applies that polarity.

Two fault sources can shut the bridge down. The first is an active-low external kill line. The second is an active-high over-current trip line. Each source passes through a two-flop synchroniser and then through a width filter. A source counts as a fault only after it has stayed asserted for a minimum number of consecutive clocks, so short glitches are rejected.

A qualified fault moves a small controller out of its running state, and all six pins then go to their off level. The fault is latched. A status field reports which source or sources caused it. Software releases the fault with a clear pulse. If the fault source is still asserted when the clear arrives, the controller waits and resumes on its own once that source has returned to idle.

The controller has three states:
- `ST_RUN`: PWM passes to the pins.
- `ST_HALT`: the fault is latched and the pins are off.
- `ST_DRAIN`: a clear has been accepted and the controller is waiting for the sources to go idle.

The transitions are:
- RUN→HALT on any qualified source.
- HALT→RUN on a clear while both sources are idle.
- HALT→DRAIN on a clear while a source is still asserted.
- DRAIN→RUN once both synchronised sources are idle.

Top module: `gate_kill_stage`

## Requirements
- R1: While `rst_n` is low and after reset, `fault_active` is 0, `fault_cause` is 0 and every pin sits at its off level, meaning `gate_out == active_low_cfg`.
- R2: Bit order of the pins is as follows: index 0 is U high, 1 is U low, 2 is V high, 3 is V low, 4 is W high and 5 is W low. `active_low_cfg[i]=1` makes pin i active-low. While running, `gate_out[i]` equals `pwm_in[i]` as sampled at the previous clock edge, XOR `active_low_cfg[i]`. This gives exactly one clock of latency.
- R3: A low pulse on `kill_n` that lasts fewer than MIN_WIDTH (32) consecutive clock samples has no effect. `fault_active` stays 0 and the pins keep following the PWM.
- R4: When `kill_n` is low for at least MIN_WIDTH samples, `fault_active` rises at the edge MIN_WIDTH+3 counted from the first low sample. The pins reach their off level one edge later, which is within 100 clocks.
- R5: `trip` is active-high and is qualified in the same way. A pulse shorter than MIN_WIDTH samples is ignored. A pulse of at least MIN_WIDTH samples raises `fault_active` at the edge MIN_WIDTH+3.
- R6: While a fault is latched, every pin is held at `active_low_cfg`, whatever `pwm_in` does. A change of `active_low_cfg` is reflected at once. The fault stays latched after its source returns to idle, until a clear arrives.
- R7: `fault_cause` bit 0 marks the kill source and bit 1 marks the trip source. Both bits are set when the two sources qualify in the same cycle. The field holds steady while the fault is latched and reads 0 while running.
- R8: A clear sampled while latched, with both synchronised sources idle, returns the block to running at that edge. The pins follow the PWM again from the next edge.
- R9: A clear sampled while a source is still asserted keeps the pins off. Once the source is released, the block resumes by itself at the third edge after the release, with no second clear.
- R10: A clear while running has no effect, and a clear held high does not prevent a qualified fault from latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 6 | Raw PWM pattern, in the pin order of R2 |
| active_low_cfg | input | 6 | Per-pin polarity; 1 selects active-low |
| kill_n | input | 1 | External kill request, active low, asynchronous |
| trip | input | 1 | Over-current trip request, active high, asynchronous |
| clear | input | 1 | Fault clear request from software |
| gate_out | output | 6 | Gate-drive pins after polarity and shutdown |
| fault_active | output | 1 | High while a fault is latched or draining |
| fault_cause | output | 2 | Bit 0: kill caused the fault; bit 1: trip caused it |

## Verification
The kill and trip filters can reach their qualification count in the same cycle. The bench provokes this by asserting both lines at once and holding them past the width. It then expects both cause bits set at the same edge where `fault_active` rises. A second collision puts a clear on the same cycles as a fault qualifies. The bench holds clear high across a whole kill pulse and judges that the fault still latches, that it drains rather than dropping, and that it resumes exactly three edges after release.

// File: rtl/gks_pkg.sv
package gks_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_DRAIN = 2'd2
    } gks_state_e;

    localparam int SRC_KILL = 0;
    localparam int SRC_TRIP = 1;
    localparam int NUM_SRC  = 2;

endpackage

// File: rtl/gks_sync.sv
module gks_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/gks_qualify.sv
module gks_qualify #(
    parameter int MIN_WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic qualified
);
    localparam int CW = $clog2(MIN_WIDTH + 1);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!level) begin
            run_len <= '0;
        end else if (run_len != CW'(MIN_WIDTH)) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign qualified = (run_len == CW'(MIN_WIDTH));
endmodule

// File: rtl/gks_ctrl.sv
module gks_ctrl
    import gks_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_qual,
    input  logic [NUM_SRC-1:0] src_busy,
    input  logic               clear,
    output logic               halted,
    output logic [NUM_SRC-1:0] cause
);
    gks_state_e state;
    gks_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (|src_qual) state_nxt = ST_HALT;
            end
            ST_HALT: begin
                if (clear) state_nxt = (|src_busy) ? ST_DRAIN : ST_RUN;
            end
            ST_DRAIN: begin
                if (!(|src_busy)) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (state == ST_RUN && (|src_qual)) begin
            cause <= src_qual;
        end else if (state_nxt == ST_RUN) begin
            cause <= '0;
        end
    end

    assign halted = (state != ST_RUN);
endmodule

// File: rtl/gks_out_stage.sv
module gks_out_stage #(
    parameter int NUM_OUT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halted,
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic [NUM_OUT-1:0] active_low_cfg,
    output logic [NUM_OUT-1:0] gate_out
);
    logic [NUM_OUT-1:0] drive;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      drive[g] <= 1'b0;
            else if (halted) drive[g] <= 1'b0;
            else             drive[g] <= pwm_in[g];
        end
        assign gate_out[g] = drive[g] ^ active_low_cfg[g];
    end
endmodule

// File: rtl/gate_kill_stage.sv
module gate_kill_stage
    import gks_pkg::*;
#(
    parameter int NUM_OUT     = 6,
    parameter int MIN_WIDTH   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic [NUM_OUT-1:0] active_low_cfg,
    input  logic               kill_n,
    input  logic               trip,
    input  logic               clear,
    output logic [NUM_OUT-1:0] gate_out,
    output logic               fault_active,
    output logic [NUM_SRC-1:0] fault_cause
);
    logic [NUM_SRC-1:0] req_raw;
    logic [NUM_SRC-1:0] req_sync;
    logic [NUM_SRC-1:0] req_qual;
    logic               halted;

    assign req_raw[SRC_KILL] = ~kill_n;
    assign req_raw[SRC_TRIP] = trip;

    gks_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_sync)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        gks_qualify #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (req_sync[k]),
            .qualified (req_qual[k])
        );
    end

    gks_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_qual (req_qual),
        .src_busy (req_sync),
        .clear    (clear),
        .halted   (halted),
        .cause    (fault_cause)
    );

    gks_out_stage #(.NUM_OUT(NUM_OUT)) u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .halted         (halted),
        .pwm_in         (pwm_in),
        .active_low_cfg (active_low_cfg),
        .gate_out       (gate_out)
    );

    assign fault_active = halted;
endmodule

// File: rtl/gks_checker.sv
module gks_checker #(
    parameter int NUM_OUT     = 6,
    parameter int MIN_WIDTH   = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OUT-1:0] pwm_in,
    input logic [NUM_OUT-1:0] active_low_cfg,
    input logic               kill_n,
    input logic               trip,
    input logic [NUM_OUT-1:0] gate_out,
    input logic               fault_active,
    input logic [1:0]         fault_cause
);
    localparam int LAT = MIN_WIDTH + SYNC_STAGES + 1;
    localparam int CW  = $clog2(LAT + 1);

    logic [CW-1:0] kill_run;
    logic [CW-1:0] trip_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kill_run <= '0;
            trip_run <= '0;
        end else begin
            if (kill_n)                   kill_run <= '0;
            else if (kill_run != CW'(LAT)) kill_run <= kill_run + 1'b1;
            if (!trip)                    trip_run <= '0;
            else if (trip_run != CW'(LAT)) trip_run <= trip_run + 1'b1;
        end
    end

    assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fault_active)) |-> ((gate_out ^ active_low_cfg) == $past(pwm_in)));

    assert_off_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_active) |-> (gate_out == active_low_cfg));

    assert_kill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_run == CW'(LAT)) |-> fault_active);

    assert_trip_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_run == CW'(LAT)) |-> fault_active);

    assert_cause_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active == (fault_cause != 2'b00));

    assert_cause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_active && $past(fault_active)) |-> $stable(fault_cause));
endmodule

bind gate_kill_stage gks_checker #(
    .NUM_OUT     (NUM_OUT),
    .MIN_WIDTH   (MIN_WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
) u_gks_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwm_in         (pwm_in),
    .active_low_cfg (active_low_cfg),
    .kill_n         (kill_n),
    .trip           (trip),
    .gate_out       (gate_out),
    .fault_active   (fault_active),
    .fault_cause    (fault_cause)
);

// File: tb/gate_kill_stage_bench.sv
module gate_kill_stage_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MINW       = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pwm_in = '0;
    logic [5:0] cfg = '0;
    logic       kill_n = 1'b1;
    logic       trip = 1'b0;
    logic       clear = 1'b0;
    logic [5:0] gate_out;
    logic       fault_active;
    logic [1:0] fault_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_kill_stage u_gate_kill_stage (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwm_in         (pwm_in),
        .active_low_cfg (cfg),
        .kill_n         (kill_n),
        .trip           (trip),
        .clear          (clear),
        .gate_out       (gate_out),
        .fault_active   (fault_active),
        .fault_cause    (fault_cause)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_pulse();
        clear = 1'b1;
        step(1);
        clear = 1'b0;
    endtask

    task automatic t_reset();
        cfg = 6'b110011;
        pwm_in = 6'b111111;
        step(3);
        check("R1 gate in reset", {2'b0, gate_out}, {2'b0, cfg});
        check("R1 fault in reset", {7'b0, fault_active}, 8'h0);
        check("R1 cause in reset", {6'b0, fault_cause}, 8'h0);
        rst_n = 1'b1;
        pwm_in = '0;
        step(2);
        check("R1 gate after reset", {2'b0, gate_out}, {2'b0, cfg});
    endtask

    task automatic t_polarity();
        logic [5:0] cfgs [4] = '{6'b000000, 6'b111111, 6'b010101, 6'b101010};
        logic [5:0] pats [4] = '{6'b000001, 6'b100100, 6'b011010, 6'b111110};
        for (int i = 0; i < 4; i++) begin
            cfg = cfgs[i];
            pwm_in = pats[i];
            step(1);
            check("R2 pattern", {2'b0, gate_out}, {2'b0, pats[i] ^ cfgs[i]});
        end
        cfg = 6'b001100;
        pwm_in = 6'b100001;
        step(1);
        pwm_in = 6'b010010;
        #1;
        check("R2 one-cycle latency old", {2'b0, gate_out}, {2'b0, 6'b100001 ^ 6'b001100});
        step(1);
        check("R2 one-cycle latency new", {2'b0, gate_out}, {2'b0, 6'b010010 ^ 6'b001100});
    endtask

    task automatic t_short_kill();
        cfg = 6'b000101;
        pwm_in = 6'b011001;
        kill_n = 1'b0;
        step(MINW - 1);
        kill_n = 1'b1;
        pwm_in = 6'b100110;
        step(MINW + 6);
        check("R3 short kill no fault", {7'b0, fault_active}, 8'h0);
        check("R3 short kill outputs follow", {2'b0, gate_out}, {2'b0, 6'b100110 ^ 6'b000101});
    endtask

    task automatic t_kill_latency();
        cfg = 6'b010001;
        pwm_in = 6'b100110;
        step(2);
        kill_n = 1'b0;
        step(MINW + 2);
        check("R4 not yet faulted", {7'b0, fault_active}, 8'h0);
        step(1);
        check("R4 fault rises", {7'b0, fault_active}, 8'h1);
        check("R7 kill cause", {6'b0, fault_cause}, 8'h1);
        check("R4 pins still driven", {2'b0, gate_out}, {2'b0, 6'b100110 ^ 6'b010001});
        step(1);
        check("R4 pins off", {2'b0, gate_out}, {2'b0, cfg});
        pwm_in = 6'b011001;
        step(3);
        check("R6 pins ignore pwm", {2'b0, gate_out}, {2'b0, cfg});
        cfg = 6'b111000;
        #1;
        check("R6 off level tracks cfg", {2'b0, gate_out}, {2'b0, 6'b111000});
        kill_n = 1'b1;
        step(4);
        check("R6 latched after release", {7'b0, fault_active}, 8'h1);
        clear_pulse();
        check("R8 clear resumes", {7'b0, fault_active}, 8'h0);
        check("R7 cause zero in run", {6'b0, fault_cause}, 8'h0);
        step(1);
        check("R8 pins follow again", {2'b0, gate_out}, {2'b0, 6'b011001 ^ 6'b111000});
    endtask

    task automatic t_trip();
        cfg = 6'b000011;
        pwm_in = 6'b110000;
        trip = 1'b1;
        step(MINW - 1);
        trip = 1'b0;
        step(MINW + 6);
        check("R5 short trip ignored", {7'b0, fault_active}, 8'h0);
        trip = 1'b1;
        step(MINW + 2);
        check("R5 trip not yet", {7'b0, fault_active}, 8'h0);
        step(1);
        check("R5 trip fault", {7'b0, fault_active}, 8'h1);
        check("R7 trip cause", {6'b0, fault_cause}, 8'h2);
        step(1);
        check("R5 pins off", {2'b0, gate_out}, {2'b0, cfg});
        trip = 1'b0;
        step(4);
        clear_pulse();
        check("R8 clear after trip", {7'b0, fault_active}, 8'h0);
    endtask

    task automatic t_drain();
        cfg = 6'b100000;
        pwm_in = 6'b001111;
        kill_n = 1'b0;
        step(MINW + 4);
        clear_pulse();
        step(3);
        check("R9 held while source busy", {7'b0, fault_active}, 8'h1);
        check("R9 pins off", {2'b0, gate_out}, {2'b0, cfg});
        check("R7 cause held", {6'b0, fault_cause}, 8'h1);
        kill_n = 1'b1;
        step(2);
        check("R9 still draining", {7'b0, fault_active}, 8'h1);
        step(1);
        check("R9 auto resume", {7'b0, fault_active}, 8'h0);
        step(1);
        check("R9 pins follow", {2'b0, gate_out}, {2'b0, 6'b001111 ^ 6'b100000});
    endtask

    task automatic t_both();
        cfg = 6'b000000;
        pwm_in = 6'b101101;
        kill_n = 1'b0;
        trip = 1'b1;
        step(MINW + 3);
        check("R7 both causes", {6'b0, fault_cause}, 8'h3);
        kill_n = 1'b1;
        trip = 1'b0;
        step(4);
        clear_pulse();
        check("R8 clear after both", {7'b0, fault_active}, 8'h0);
    endtask

    task automatic t_clear_run();
        cfg = 6'b011110;
        pwm_in = 6'b000111;
        clear = 1'b1;
        step(3);
        check("R10 clear in run inert", {7'b0, fault_active}, 8'h0);
        check("R10 pins follow with clear", {2'b0, gate_out}, {2'b0, 6'b000111 ^ 6'b011110});
        kill_n = 1'b0;
        step(MINW + 3);
        check("R10 fault despite clear", {7'b0, fault_active}, 8'h1);
        step(3);
        check("R10 stays off while busy", {2'b0, gate_out}, {2'b0, cfg});
        kill_n = 1'b1;
        step(3);
        check("R10 resumes after release", {7'b0, fault_active}, 8'h0);
        clear = 1'b0;
        step(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_polarity();
        t_short_kill();
        t_kill_latency();
        t_trip();
        t_drain();
        t_both();
        t_clear_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule